// File: doc/BRIEF.md
# Command Fetch and Stall Controller

This block sits at the front of a command-processing engine. Quadwords of four 32-bit command words are pushed into a small internal FIFO. The controller takes words from the FIFO one at a time, starting with the least significant word of each quadword. It splits each word into its interrupt flag, opcode, count and immediate, and then either hands the command to an execution unit or stalls. Execution itself is outside this block. It is reduced to a handshake: the block raises `exec_valid`, and the executor answers with `exec_done`. With that answer the executor may also report a DMA alignment mismatch.

A status word shows the processing state and four sticky bits: interrupt seen, interrupt stall, DMA mismatch and bad code. A three-bit mask register controls three stall causes. One bit suppresses the interrupt stall, one ignores DMA mismatches, and one makes unknown opcodes be skipped silently. A host control write can reset the engine, or clear the stall bits so that execution resumes. A word that carries the interrupt flag is held back on its first decode. After a resume the same word runs exactly once, because a loop-prevention flag records that it has already been flagged. The mark command is the exception: it runs at once even with the flag set.

Top module: `cmd_fetch_ctrl`

## Requirements
- R1: For each command run, `exec_op`, `exec_num` and `exec_imm` equal bits 30:24, 23:16 and 15:0 of the word. Words within a quadword run from bits 31:0 upward.
- R2: A word is taken only when the FIFO holds a quadword. `code` then shows the word at the read position. The state field (`status[1:0]`: 0 idle, 1 wait, 2 decode, 3 stall) moves from idle to decode to wait.
- R3: `exec_valid` stays high with a stable opcode until `exec_done`. Only then does the engine go on to the next word.
- R4: An unknown opcode with mask bit 2 clear sets `status[13]`, enters stall and skips that word.
- R5: An unknown opcode with mask bit 2 set is skipped without setting any bit, and fetching continues.
- R6: Legal opcodes on instance 0 are 0x00, 0x01, 0x04, 0x05, 0x07, 0x10, 0x14, 0x17, 0x20, 0x30, 0x31, 0x4A, 0x50, 0x51 and 0x60–0x7F. Opcodes 0x02, 0x03, 0x06, 0x11, 0x13 and 0x15 are legal only when ENGINE_ID is 1. Every other opcode is unknown.
- R7: On its first decode, a word with bit 31 set and mask bit 0 clear sets `status[11]` and `status[10]`. It enters stall without running.
- R8: With mask bit 0 set, an interrupt word sets `status[11]` only, and runs without stalling.
- R9: The mark opcode 0x07 with bit 31 set runs at once. The raised `status[10]` then stalls the engine before the next word.
- R10: A control write with bit 3 clears `status[13:10]` and resumes. A word suspended by its interrupt flag then runs exactly once.
- R11: `dma_err` given with `exec_done` and mask bit 1 clear sets `status[12]`. The current command completes, and the engine stalls before the next word. With mask bit 1 set, `dma_err` is ignored.
- R12: A control write with bit 0 clears the status, mask, code and loop flag, and empties the FIFO.
- R13: `qw_ready` is low exactly when the FIFO holds FIFO_DEPTH quadwords.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qw_valid | input | 1 | Quadword push strobe |
| qw_data | input | 128 | Quadword of four command words |
| qw_ready | output | 1 | FIFO can accept a quadword |
| ctrl_wr | input | 1 | Host control write strobe |
| ctrl_wdata | input | 4 | Bit 0 engine reset, bit 3 stall cancel |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 3 | New mask value |
| mask_q | output | 3 | Current mask register |
| status | output | 16 | State field and sticky bits |
| code | output | 32 | Last fetched command word |
| exec_valid | output | 1 | Command handed to the executor |
| exec_op | output | 7 | Opcode of the command |
| exec_num | output | 8 | Count field |
| exec_imm | output | 16 | Immediate field |
| exec_done | input | 1 | Executor has finished the command |
| dma_err | input | 1 | Alignment mismatch reported with `exec_done` |

## Verification
A corrupted loop-prevention flag shows up within one decode. An interrupt word either runs twice across a resume, or never runs after the stall cancel, and the bench counts the commands it sees executed. A wrong read position or a skipped advance changes the sequence of opcodes seen on `exec_op` from the very next command. A stall bit that is wrongly dropped or kept is visible in `status` and in `exec_valid` within a few cycles of the word that should have stalled.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  localparam int WORD_W   = 32;
  localparam int QW_WORDS = 4;
  localparam int QW_BITS  = WORD_W * QW_WORDS;
  localparam int STAT_W   = 16;

  // status bit positions
  localparam int SB_PIS = 10;
  localparam int SB_INT = 11;
  localparam int SB_DMA = 12;
  localparam int SB_BAD = 13;

  // mask bit positions
  localparam int MB_INT = 0;
  localparam int MB_DMA = 1;
  localparam int MB_BAD = 2;

  // control bit positions
  localparam int CB_RST    = 0;
  localparam int CB_CANCEL = 3;

  localparam logic [6:0] OP_MARK = 7'h07;

  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_WAIT   = 2'd1,
    PS_DECODE = 2'd2,
    PS_STALL  = 2'd3
  } pstate_e;

  typedef struct packed {
    logic        irq;
    logic [6:0]  op;
    logic [7:0]  num;
    logic [15:0] imm;
  } cmd_word_t;
endpackage

// File: rtl/cmd_qfifo.sv
module cmd_qfifo #(
  parameter int DEPTH = 4,
  parameter int WORDS = 4,
  parameter int WW    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                push,
  input  logic [WORDS*WW-1:0] push_data,
  input  logic                adv,
  output logic                ready,
  output logic                avail,
  output logic [WW-1:0]       word
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int XW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [WORDS*WW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [XW-1:0] widx;
  logic do_push, step, pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign ready   = (cnt != CW'(DEPTH));
  assign avail   = (cnt != '0);
  assign do_push = push && ready;
  assign step    = adv && avail;
  assign pop     = step && (widx == XW'(WORDS - 1));
  assign word    = mem[rp][widx*WW +: WW];

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      widx <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (step)    widx <= (widx == XW'(WORDS - 1)) ? '0 : widx + 1'b1;
      if (pop)     rp <= nxt(rp);
      case ({do_push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/cmd_opcheck.sv
module cmd_opcheck #(
  parameter int ENGINE_ID = 0
) (
  input  logic [6:0] op,
  output logic       legal
);
  logic base_ok, ext_ok;

  always_comb begin
    base_ok = (op[6:5] == 2'b11) ||
              (op inside {7'h00, 7'h01, 7'h04, 7'h05, 7'h07, 7'h10, 7'h14,
                          7'h17, 7'h20, 7'h30, 7'h31, 7'h4A, 7'h50, 7'h51});
  end

  generate
    if (ENGINE_ID == 1) begin : g_ext
      always_comb ext_ok = op inside {7'h02, 7'h03, 7'h06, 7'h11, 7'h13, 7'h15};
    end else begin : g_noext
      assign ext_ok = 1'b0;
    end
  endgenerate

  assign legal = base_ok | ext_ok;
endmodule

// File: rtl/cmd_fetch_ctrl.sv
module cmd_fetch_ctrl
  import cmd_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int ENGINE_ID  = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               qw_valid,
  input  logic [QW_BITS-1:0] qw_data,
  output logic               qw_ready,
  input  logic               ctrl_wr,
  input  logic [3:0]         ctrl_wdata,
  input  logic               mask_wr,
  input  logic [2:0]         mask_wdata,
  output logic [2:0]         mask_q,
  output logic [STAT_W-1:0]  status,
  output logic [WORD_W-1:0]  code,
  output logic               exec_valid,
  output logic [6:0]         exec_op,
  output logic [7:0]         exec_num,
  output logic [15:0]        exec_imm,
  input  logic               exec_done,
  input  logic               dma_err
);
  pstate_e state_q;
  logic [WORD_W-1:0] code_q;
  logic [2:0] mask_r;
  logic noloop_q, st_int, st_pis, st_dma, st_bad;

  logic host_rst, cancel, avail, adv, op_legal;
  logic [WORD_W-1:0] fifo_word;
  logic first_irq, suspend, bad, stall_any;
  cmd_word_t cw;

  assign host_rst = ctrl_wr && ctrl_wdata[CB_RST];
  assign cancel   = ctrl_wr && ctrl_wdata[CB_CANCEL];

  cmd_qfifo #(.DEPTH(FIFO_DEPTH), .WORDS(QW_WORDS), .WW(WORD_W)) u_fifo (
    .clk(clk), .rst(rst), .flush(host_rst),
    .push(qw_valid), .push_data(qw_data), .adv(adv),
    .ready(qw_ready), .avail(avail), .word(fifo_word)
  );

  assign cw = cmd_word_t'(code_q);

  cmd_opcheck #(.ENGINE_ID(ENGINE_ID)) u_opcheck (.op(cw.op), .legal(op_legal));

  // decode view of the held word
  assign first_irq = cw.irq && !noloop_q;
  assign suspend   = first_irq && (cw.op != OP_MARK);
  assign bad       = !suspend && !op_legal;
  assign stall_any = st_dma || st_bad || st_pis;
  assign adv       = ((state_q == PS_WAIT) && exec_done) ||
                     ((state_q == PS_DECODE) && bad);

  always_ff @(posedge clk) begin
    if (rst || host_rst) begin
      state_q  <= PS_IDLE;
      code_q   <= '0;
      mask_r   <= '0;
      noloop_q <= 1'b0;
      st_int   <= 1'b0;
      st_pis   <= 1'b0;
      st_dma   <= 1'b0;
      st_bad   <= 1'b0;
    end else begin
      if (mask_wr) mask_r <= mask_wdata;
      if (cancel) begin
        st_int <= 1'b0;
        st_pis <= 1'b0;
        st_dma <= 1'b0;
        st_bad <= 1'b0;
      end
      case (state_q)
        PS_IDLE, PS_STALL: begin
          if (avail) code_q <= fifo_word;
          if (stall_any)  state_q <= PS_STALL;
          else if (avail) state_q <= PS_DECODE;
          else            state_q <= PS_IDLE;
        end
        PS_DECODE: begin
          if (first_irq) begin
            st_int   <= 1'b1;
            noloop_q <= 1'b1;
            if (!mask_r[MB_INT]) st_pis <= 1'b1;
          end else if (cw.irq) begin
            noloop_q <= 1'b0;
          end
          if (suspend) begin
            state_q <= PS_STALL;
          end else if (bad) begin
            noloop_q <= 1'b0;
            if (!mask_r[MB_BAD]) begin
              st_bad  <= 1'b1;
              state_q <= PS_STALL;
            end else begin
              state_q <= PS_IDLE;
            end
          end else begin
            state_q <= PS_WAIT;
          end
        end
        PS_WAIT: begin
          if (exec_done) begin
            if (dma_err && !mask_r[MB_DMA]) st_dma <= 1'b1;
            noloop_q <= 1'b0;
            state_q  <= PS_IDLE;
          end
        end
        default: state_q <= PS_IDLE;
      endcase
    end
  end

  always_comb begin
    status         = '0;
    status[1:0]    = state_q;
    status[SB_PIS] = st_pis;
    status[SB_INT] = st_int;
    status[SB_DMA] = st_dma;
    status[SB_BAD] = st_bad;
  end

  assign mask_q     = mask_r;
  assign code       = code_q;
  assign exec_valid = (state_q == PS_WAIT);
  assign exec_op    = cw.op;
  assign exec_num   = cw.num;
  assign exec_imm   = cw.imm;
endmodule

// File: rtl/cmd_fetch_ctrl_chk.sv
module cmd_fetch_ctrl_chk
  import cmd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ctrl_wr,
  input logic [3:0]        ctrl_wdata,
  input logic [2:0]        mask_q,
  input logic [STAT_W-1:0] status,
  input logic [WORD_W-1:0] code,
  input logic              exec_valid,
  input logic [6:0]        exec_op,
  input logic              exec_done,
  input logic              qw_ready
);
  AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (rst) (exec_valid && !exec_done && !(ctrl_wr && ctrl_wdata[0])) |=> (exec_valid && $stable(exec_op))); // R3
  AST_BAD_STALLS: assert property (@(posedge clk) disable iff (rst) $rose(status[13]) |-> (status[1:0] == 2'd3)); // R4
  AST_INT_SUSPEND: assert property (@(posedge clk) disable iff (rst) ($rose(status[10]) && (code[30:24] != OP_MARK)) |-> (status[1:0] == 2'd3)); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst) ((|status[13:10] && !status[11]) || status[10] || status[12] || status[13]) && (status[1:0] == 2'd3) && !ctrl_wr |=> (status[1:0] == 2'd3)); // R7
  AST_MASKED_INT: assert property (@(posedge clk) disable iff (rst) $rose(status[10]) |-> !$past(mask_q[0])); // R8
  AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (rst) (ctrl_wr && ctrl_wdata[3] && (status[1:0] == 2'd3)) |=> (status[13:10] == 4'd0)); // R10
  AST_HOST_RESET: assert property (@(posedge clk) disable iff (rst) (ctrl_wr && ctrl_wdata[0]) |=> ((status == '0) && !exec_valid && qw_ready && (mask_q == 3'd0))); // R12
endmodule

bind cmd_fetch_ctrl cmd_fetch_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
  .mask_q(mask_q), .status(status), .code(code), .exec_valid(exec_valid),
  .exec_op(exec_op), .exec_done(exec_done), .qw_ready(qw_ready)
);

// File: tb/sim_cmd_fetch_ctrl.sv
`timescale 1ns/1ps
module sim_cmd_fetch_ctrl;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst = 1'b1;
  logic         qw_valid = 1'b0;
  logic [127:0] qw_data = '0;
  logic         qw_ready;
  logic         ctrl_wr = 1'b0;
  logic [3:0]   ctrl_wdata = '0;
  logic         mask_wr = 1'b0;
  logic [2:0]   mask_wdata = '0;
  logic [2:0]   mask_q;
  logic [15:0]  status;
  logic [31:0]  code;
  logic         exec_valid;
  logic [6:0]   exec_op;
  logic [7:0]   exec_num;
  logic [15:0]  exec_imm;
  logic         exec_done = 1'b0;
  logic         dma_err = 1'b0;

  cmd_fetch_ctrl #(.FIFO_DEPTH(DEPTH), .ENGINE_ID(0)) u0 (
    .clk(clk), .rst(rst), .qw_valid(qw_valid), .qw_data(qw_data), .qw_ready(qw_ready),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .mask_q(mask_q), .status(status), .code(code), .exec_valid(exec_valid),
    .exec_op(exec_op), .exec_num(exec_num), .exec_imm(exec_imm),
    .exec_done(exec_done), .dma_err(dma_err)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // executor model
  bit rsp_en = 1;
  bit rsp_dma = 0;
  int dly = 0;
  int rec_n = 0;
  logic [6:0]  rec_op  [16];
  logic [7:0]  rec_num [16];
  logic [15:0] rec_imm [16];

  always @(negedge clk) begin
    if (exec_done) begin
      exec_done = 1'b0;
      dma_err   = 1'b0;
    end else if (rsp_en && exec_valid) begin
      if (dly > 0) dly--;
      else begin
        if (rec_n < 16) begin
          rec_op[rec_n]  = exec_op;
          rec_num[rec_n] = exec_num;
          rec_imm[rec_n] = exec_imm;
        end
        rec_n++;
        exec_done = 1'b1;
        dma_err   = rsp_dma;
        rsp_dma   = 0;
        dly       = $urandom % 3;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_ctrl(input logic [3:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic set_mask(input logic [2:0] m);
    @(negedge clk); mask_wr = 1'b1; mask_wdata = m;
    @(negedge clk); mask_wr = 1'b0;
  endtask

  task automatic push_qw(input logic [127:0] d);
    @(negedge clk); qw_valid = 1'b1; qw_data = d;
    @(negedge clk); qw_valid = 1'b0;
  endtask

  // legal opcode set for instance 0 (R6)
  function automatic bit op_ok(input logic [6:0] op);
    if (op >= 7'h60) return 1;
    case (op)
      7'h00, 7'h01, 7'h04, 7'h05, 7'h07, 7'h10, 7'h14,
      7'h17, 7'h20, 7'h30, 7'h31, 7'h4A, 7'h50, 7'h51: return 1;
      default: return 0;
    endcase
  endfunction

  // one word followed by three no-ops; expectations from the requirements
  task automatic trial(input logic [31:0] w, input logic [2:0] m, input string req);
    logic irq;
    logic [6:0] op;
    int n1, nf;
    bit stalls;
    logic [15:0] st1;
    logic [31:0] code1;
    logic [6:0] first_exp;
    irq = w[31];
    op  = w[30:24];
    host_ctrl(4'h1);
    set_mask(m);
    rec_n = 0;
    push_qw({96'h0, w});
    idle(40);
    if (irq && !m[0]) begin
      stalls = 1; st1 = 16'h0C03; nf = 4; first_exp = op;
      if (op == 7'h07) begin n1 = 1; code1 = 32'h0; end
      else begin n1 = 0; code1 = w; end
    end else if (!op_ok(op)) begin
      nf = 3; first_exp = 7'h00; code1 = 32'h0;
      if (!m[2]) begin stalls = 1; n1 = 0; st1 = 16'h2003; end
      else begin stalls = 0; n1 = 3; st1 = 16'h0000; end
    end else begin
      stalls = 0; n1 = 4; nf = 4; first_exp = op; code1 = 32'h0;
      st1 = irq ? 16'h0800 : 16'h0000;
    end
    chk(req, 32'(rec_n), 32'(n1), "commands before stall");
    chk(req, {16'h0, status}, {16'h0, st1}, "status");
    chk(req, code, code1, "code register");
    if (stalls) begin
      host_ctrl(4'h8);
      idle(40);
      chk("R10", {16'h0, status}, 32'h0, "status after cancel");
      chk("R10", 32'(rec_n), 32'(nf), "commands after cancel");
    end
    if (rec_n > 0) chk(req, {25'h0, rec_op[0]}, {25'h0, first_exp}, "first opcode");
    if (nf == 4 && rec_n > 0) begin
      chk("R1", {24'h0, rec_num[0]}, {24'h0, w[23:16]}, "count field");
      chk("R1", {16'h0, rec_imm[0]}, {16'h0, w[15:0]}, "immediate field");
    end
  endtask

  logic [6:0] bad_pool [7] = '{7'h08, 7'h0C, 7'h22, 7'h40, 7'h02, 7'h03, 7'h11};
  logic [6:0] good_pool [13] = '{7'h01, 7'h04, 7'h05, 7'h07, 7'h10, 7'h14, 7'h17,
                                 7'h20, 7'h30, 7'h31, 7'h4A, 7'h50, 7'h51};

  initial begin
    void'($urandom(32'd7));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R12)
    chk("R12", {16'h0, status}, 32'h0, "status after reset");
    chk("R12", code, 32'h0, "code after reset");
    chk("R12", {31'h0, exec_valid}, 32'h0, "exec_valid after reset");
    chk("R13", {31'h0, qw_ready}, 32'h1, "qw_ready after reset");
    idle(5);
    chk("R2", {30'h0, status[1:0]}, 32'h0, "idle with empty FIFO");

    // R2/R3: word held in wait until done
    rsp_en = 0;
    rec_n = 0;
    push_qw({96'h0, 32'h0512_3456});
    idle(8);
    chk("R2", code, 32'h0512_3456, "code shows fetched word");
    chk("R3", {30'h0, status[1:0]}, 32'h1, "state wait");
    chk("R3", {31'h0, exec_valid}, 32'h1, "exec_valid held");
    chk("R1", {25'h0, exec_op}, 32'h05, "opcode field");
    rsp_en = 1;
    idle(30);
    chk("R3", 32'(rec_n), 32'd4, "commands after done");

    // R13 / R12: fill and flush
    rsp_en = 0;
    host_ctrl(4'h1);
    for (int i = 0; i < DEPTH; i++) push_qw({96'h0, 32'h0100_0000});
    idle(2);
    chk("R13", {31'h0, qw_ready}, 32'h0, "qw_ready when full");
    host_ctrl(4'h1);
    chk("R12", {31'h0, qw_ready}, 32'h1, "FIFO emptied by host reset");
    chk("R12", {31'h0, exec_valid}, 32'h0, "exec dropped by host reset");
    rsp_en = 1;

    // directed words
    trial(32'h0500_0003, 3'b000, "R1");
    trial(32'h0800_0000, 3'b000, "R4");
    trial(32'h0800_0000, 3'b100, "R5");
    trial(32'h0300_0011, 3'b000, "R6");
    trial(32'h8500_0000, 3'b000, "R7");
    trial(32'h8500_0001, 3'b001, "R8");
    trial(32'h8700_B00F, 3'b000, "R9");

    // R11: DMA mismatch unmasked then masked
    host_ctrl(4'h1);
    rec_n = 0;
    rsp_dma = 1;
    push_qw({96'h0, 32'h0100_0005});
    idle(40);
    chk("R11", 32'(rec_n), 32'd1, "command finished before stall");
    chk("R11", {16'h0, status}, 32'h1003, "status on mismatch");
    host_ctrl(4'h8);
    idle(40);
    chk("R11", 32'(rec_n), 32'd4, "resume after mismatch");
    host_ctrl(4'h1);
    set_mask(3'b010);
    rec_n = 0;
    rsp_dma = 1;
    push_qw({96'h0, 32'h0100_0005});
    idle(40);
    chk("R11", 32'(rec_n), 32'd4, "masked mismatch ignored");
    chk("R11", {16'h0, status}, 32'h0, "masked mismatch status");

    // constrained random words
    for (int t = 0; t < 40; t++) begin
      logic [31:0] w;
      logic [2:0] m;
      bit use_bad;
      use_bad = ($urandom % 4) == 0;
      m = 3'($urandom);
      w[23:0] = 24'($urandom);
      if (use_bad) begin
        w[31] = 1'b0;
        w[30:24] = bad_pool[$urandom % 7];
      end else begin
        w[31] = (($urandom % 3) == 0);
        if (($urandom % 4) == 0) w[30:24] = 7'h60 + 7'($urandom % 32);
        else w[30:24] = good_pool[$urandom % 13];
      end
      trial(w, m, use_bad ? "R4" : "R7");
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule